// File: doc/BRIEF.md
# Seven-Row Column-Counter Adder

This block adds seven unsigned operand rows of a parameterised width and returns their exact binary sum. Rather than chaining two-input adders, it compresses every bit column at once: a seven-input column counter, built from explicit gates, turns the seven bits of equal weight into a three-bit count. The counts of all columns are placed by weight into three rows. A single carry-propagate stage then adds those three rows into the final result.

Inside each column counter the seven inputs are split into two groups. A low group of three bits is counted by a full adder. A high group of four bits is counted by a small half-adder network. The two partial counts are merged with a one-level lookahead carry. The sum path is purely combinational. An optional output register, selected by a parameter, makes the result appear one clock after the inputs.

Top module: `sevenRowSum`

## Requirements
- R1: With the default register option, `sumOut` equals the arithmetic sum of the seven rows, `opRow0` to `opRow6`, taken one clock edge earlier.
- R2: The result is OPER_W+3 bits wide. Seven all-ones rows give exactly 7*(2^OPER_W-1), with no wrap.
- R3: While `rstN` is low, `sumOut` is zero (asynchronous, active-low). With REG_OUT=1 the output changes only at a rising clock edge, one cycle after the inputs.
- R4: Each column is counted independently. If k rows (0 to 7) carry a one in column j and every other bit is zero, the result is k*2^j.
- R5: The high input group (rows 3 to 6) counts four ones correctly: four all-ones rows in that group, with the other rows zero, give 4*(2^OPER_W-1).
- R6: The low input group (rows 0 to 2) counts three ones correctly: three all-ones rows in that group, with the other rows zero, give 3*(2^OPER_W-1).
- R7: Merging the two partial counts handles every carry path. A column whose low-group count is 3 and high-group count is 1 yields 4. Counts of 1 and 2 yield 3. Counts of 2 and 4 yield 6.
- R8: All-zero rows give a zero sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Asynchronous active-low reset |
| opRow0 | input | OPER_W | Operand row 0 (low group) |
| opRow1 | input | OPER_W | Operand row 1 (low group) |
| opRow2 | input | OPER_W | Operand row 2 (low group) |
| opRow3 | input | OPER_W | Operand row 3 (high group) |
| opRow4 | input | OPER_W | Operand row 4 (high group) |
| opRow5 | input | OPER_W | Operand row 5 (high group) |
| opRow6 | input | OPER_W | Operand row 6 (high group) |
| sumOut | output | OPER_W+3 | Sum of the seven rows |

## Verification
Single-column patterns sweep the count from 0 to 7 in every column. A wrong counter output bit, or a misplaced weight when the counts are aligned into rows, shows up at one exact power-of-two multiple. Group-saturating patterns fill only the low three rows or only the high four rows. These separate a fault in the full adder from a fault in the four-input counter, including its four-ones code. Mixed-count columns drive the merge through its generate and propagate carry paths. Random full-width vectors, checked against an arithmetic sum, catch faults in the carry-propagate stage that the sparse patterns never excite.

// File: rtl/srs_pkg.sv
package srs_pkg;
  localparam int ROWS = 7;
  localparam int CNT_W = 3;

  typedef struct packed {
    logic capture;
    logic hold;
  } srsStrobeT;
endpackage

// File: rtl/srsColCounter.sv
module srsColCounter (
  input  logic [6:0] colIn,
  output logic [2:0] cntOut
);
  logic sumA, carA;
  logic pB, gB, rB, hB;
  logic cntB0, cntB1, cntB2;
  logic gen0, gen1, prop1, carLow;

  // low group: three bits through a full adder
  always_comb begin
    sumA = colIn[0] ^ colIn[1] ^ colIn[2];
    carA = (colIn[0] & colIn[1]) | (colIn[0] & colIn[2]) | (colIn[1] & colIn[2]);
  end

  // high group: four bits, two half adders then a combine
  always_comb begin
    pB    = colIn[3] ^ colIn[4];
    gB    = colIn[3] & colIn[4];
    rB    = colIn[5] ^ colIn[6];
    hB    = colIn[5] & colIn[6];
    cntB0 = pB ^ rB;
    cntB1 = gB ^ hB ^ (pB & rB);
    cntB2 = gB & hB;
  end

  // merge with one level of lookahead
  always_comb begin
    gen0   = sumA & cntB0;
    gen1   = carA & cntB1;
    prop1  = carA ^ cntB1;
    carLow = gen1 | (prop1 & gen0);
    cntOut = {cntB2 ^ carLow, prop1 ^ gen0, sumA ^ cntB0};
  end
endmodule

// File: rtl/srsCounterBank.sv
module srsCounterBank #(
  parameter int OPER_W = 8
) (
  input  logic [OPER_W-1:0] rowsIn [srs_pkg::ROWS],
  output logic [OPER_W+2:0] rowLo,
  output logic [OPER_W+2:0] rowMid,
  output logic [OPER_W+2:0] rowHi
);
  logic [6:0] colBits [OPER_W];
  logic [OPER_W-1:0] w0Bits, w1Bits, w2Bits;

  for (genvar col = 0; col < OPER_W; col++) begin : g_col
    for (genvar r = 0; r < srs_pkg::ROWS; r++) begin : g_row
      assign colBits[col][r] = rowsIn[r][col];
    end
    logic [2:0] cnt;
    srsColCounter cnt_i (.colIn(colBits[col]), .cntOut(cnt));
    assign w0Bits[col] = cnt[0];
    assign w1Bits[col] = cnt[1];
    assign w2Bits[col] = cnt[2];
  end

  assign rowLo  = {3'b000, w0Bits};
  assign rowMid = {2'b00, w1Bits, 1'b0};
  assign rowHi  = {1'b0, w2Bits, 2'b00};
endmodule

// File: rtl/srsCarryAdder.sv
module srsCarryAdder #(
  parameter int SUM_W = 11
) (
  input  logic [SUM_W-1:0] inX,
  input  logic [SUM_W-1:0] inY,
  input  logic [SUM_W-1:0] inZ,
  output logic [SUM_W-1:0] sumV
);
  logic [SUM_W-1:0] csSum, csCar;
  logic [SUM_W-1:0] rip;

  // 3:2 layer; the top majority bit is always zero because the total fits
  assign csCar[0] = 1'b0;
  for (genvar b = 0; b < SUM_W; b++) begin : g_csa
    assign csSum[b] = inX[b] ^ inY[b] ^ inZ[b];
    if (b < SUM_W - 1) begin : g_maj
      assign csCar[b+1] = (inX[b] & inY[b]) | (inX[b] & inZ[b]) | (inY[b] & inZ[b]);
    end
  end

  // ripple carry-propagate stage
  assign rip[0] = 1'b0;
  for (genvar b = 0; b < SUM_W; b++) begin : g_rip
    assign sumV[b] = csSum[b] ^ csCar[b] ^ rip[b];
    if (b < SUM_W - 1) begin : g_cy
      assign rip[b+1] = (csSum[b] & csCar[b]) | (rip[b] & (csSum[b] ^ csCar[b]));
    end
  end
endmodule

// File: rtl/srsDatapath.sv
module srsDatapath #(
  parameter int OPER_W  = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [OPER_W-1:0]    rowsIn [srs_pkg::ROWS],
  input  srs_pkg::srsStrobeT   strobe,
  output logic [OPER_W+2:0]    sumOut
);
  localparam int SUM_W = OPER_W + 3;

  logic [SUM_W-1:0] rowLo, rowMid, rowHi, sumComb;

  srsCounterBank #(.OPER_W(OPER_W)) bank_i (
    .rowsIn(rowsIn), .rowLo(rowLo), .rowMid(rowMid), .rowHi(rowHi)
  );

  srsCarryAdder #(.SUM_W(SUM_W)) cpa_i (
    .inX(rowLo), .inY(rowMid), .inZ(rowHi), .sumV(sumComb)
  );

  if (REG_OUT) begin : g_reg
    logic [SUM_W-1:0] sumQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                          sumQ <= '0;
      else if (strobe.capture && !strobe.hold) sumQ <= sumComb;
    end
    assign sumOut = sumQ;
  end else begin : g_comb
    assign sumOut = (rstN && !strobe.hold) ? sumComb : '0;
  end
endmodule

// File: rtl/srsControl.sv
module srsControl (
  input  logic               rstN,
  output srs_pkg::srsStrobeT strobe
);
  always_comb begin
    strobe.capture = rstN;
    strobe.hold    = 1'b0;
  end
endmodule

// File: rtl/sevenRowSum.sv
module sevenRowSum #(
  parameter int OPER_W  = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [OPER_W-1:0] opRow0,
  input  logic [OPER_W-1:0] opRow1,
  input  logic [OPER_W-1:0] opRow2,
  input  logic [OPER_W-1:0] opRow3,
  input  logic [OPER_W-1:0] opRow4,
  input  logic [OPER_W-1:0] opRow5,
  input  logic [OPER_W-1:0] opRow6,
  output logic [OPER_W+2:0] sumOut
);
  logic [OPER_W-1:0] rowsIn [srs_pkg::ROWS];
  srs_pkg::srsStrobeT strobe;

  assign rowsIn[0] = opRow0;
  assign rowsIn[1] = opRow1;
  assign rowsIn[2] = opRow2;
  assign rowsIn[3] = opRow3;
  assign rowsIn[4] = opRow4;
  assign rowsIn[5] = opRow5;
  assign rowsIn[6] = opRow6;

  srsControl ctrl_i (.rstN(rstN), .strobe(strobe));

  srsDatapath #(.OPER_W(OPER_W), .REG_OUT(REG_OUT)) dp_i (
    .clk(clk), .rstN(rstN), .rowsIn(rowsIn), .strobe(strobe), .sumOut(sumOut)
  );
endmodule

// File: rtl/srsChecker.sv
module srsChecker #(
  parameter int OPER_W  = 8,
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic [OPER_W-1:0] opRow0,
  input logic [OPER_W-1:0] opRow1,
  input logic [OPER_W-1:0] opRow2,
  input logic [OPER_W-1:0] opRow3,
  input logic [OPER_W-1:0] opRow4,
  input logic [OPER_W-1:0] opRow5,
  input logic [OPER_W-1:0] opRow6,
  input logic [OPER_W+2:0] sumOut
);
  localparam int SUM_W = OPER_W + 3;
  localparam logic [SUM_W-1:0] ROW_MAX = {3'b000, {OPER_W{1'b1}}};
  localparam logic [SUM_W-1:0] SUM_MAX = ROW_MAX * 7;

  logic [SUM_W-1:0] rowTotal;
  logic allOnes, allZero;
  assign rowTotal = SUM_W'(opRow0) + SUM_W'(opRow1) + SUM_W'(opRow2) + SUM_W'(opRow3)
                  + SUM_W'(opRow4) + SUM_W'(opRow5) + SUM_W'(opRow6);
  assign allOnes = &{opRow0, opRow1, opRow2, opRow3, opRow4, opRow5, opRow6};
  assign allZero = ~|{opRow0, opRow1, opRow2, opRow3, opRow4, opRow5, opRow6};

  if (REG_OUT) begin : g_chk
    AST_SUM_MATCH: assert property (@(posedge clk) disable iff (!rstN)
      1'b1 |=> sumOut == $past(rowTotal)); // R1
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
      sumOut <= SUM_MAX); // R2
    AST_FULL_ROWS: assert property (@(posedge clk) disable iff (!rstN)
      allOnes |=> sumOut == SUM_MAX); // R2
    AST_RESET_ZERO: assert property (@(posedge clk)
      !rstN |=> sumOut == '0); // R3
    AST_ZERO_ROWS: assert property (@(posedge clk) disable iff (!rstN)
      allZero |=> sumOut == '0); // R8
  end
endmodule

bind sevenRowSum srsChecker #(.OPER_W(OPER_W), .REG_OUT(REG_OUT)) chk_i (
  .clk(clk), .rstN(rstN), .opRow0(opRow0), .opRow1(opRow1), .opRow2(opRow2),
  .opRow3(opRow3), .opRow4(opRow4), .opRow5(opRow5), .opRow6(opRow6), .sumOut(sumOut)
);

// File: tb/sevenRowSum_tb_top.sv
module sevenRowSum_tb_top;
  localparam int OPER_W = 8;
  localparam int SUM_W  = OPER_W + 3;
  localparam int NVEC   = 10;

  // rows packed with opRow0 in the top byte
  localparam logic [55:0] STIM [NVEC] = '{
    56'h00000000000000, 56'hFFFFFFFFFFFFFF, 56'hFFFFFF00000000, 56'h000000FFFFFFFF,
    56'h01020408102040, 56'h01010101000000, 56'h80000080800000, 56'h01010001010101,
    56'h123456789ABCDE, 56'hAA55AA55AA55AA };
  localparam int EXPV [NVEC] = '{0, 1785, 765, 1020, 127, 4, 384, 6, 840, 935};
  localparam string TAGS [NVEC] = '{"R8", "R2", "R6", "R5", "R1", "R7", "R7", "R7", "R1", "R1"};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [OPER_W-1:0] r0, r1, r2, r3, r4, r5, r6;
  logic [SUM_W-1:0] sumOut;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sevenRowSum #(.OPER_W(OPER_W), .REG_OUT(1'b1)) dut_i (
    .clk(clk), .rstN(rstN), .opRow0(r0), .opRow1(r1), .opRow2(r2), .opRow3(r3),
    .opRow4(r4), .opRow5(r5), .opRow6(r6), .sumOut(sumOut));

  task automatic setRows(input logic [55:0] v);
    {r0, r1, r2, r3, r4, r5, r6} = v;
  endtask

  task automatic check(input string tag, input int exp);
    checks++;
    if (int'(sumOut) != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, sumOut, exp);
    end
  endtask

  task automatic applyCheck(input logic [55:0] v, input int exp, input string tag);
    @(negedge clk);
    setRows(v);
    @(negedge clk);
    check(tag, exp);
  endtask

  initial begin
    #3000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    setRows(56'hFFFFFFFFFFFFFF);
    repeat (3) @(negedge clk);
    check("R3 reset", 0);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) applyCheck(STIM[i], EXPV[i], TAGS[i]);

    // R4: k ones in column j
    for (int j = 0; j < OPER_W; j++) begin
      for (int k = 0; k <= 7; k++) begin
        logic [55:0] v;
        v = '0;
        for (int r = 0; r < k; r++) v[8*(6-r) + j] = 1'b1;
        applyCheck(v, k << j, "R4");
      end
    end

    // R1: random rows against an arithmetic sum
    for (int n = 0; n < 300; n++) begin
      logic [55:0] v;
      int exp;
      v = {$urandom, $urandom};
      exp = 0;
      for (int r = 0; r < 7; r++) exp += int'(v[8*r +: 8]);
      applyCheck(v, exp, "R1");
    end

    // R3: output only moves at the clock edge
    applyCheck(56'h01000000000000, 1, "R3");
    @(negedge clk);
    setRows(56'hFFFFFFFFFFFFFF);
    #5 check("R3 hold", 1);
    @(negedge clk);
    check("R3 update", 1785);
    // R3: asynchronous reset mid-run
    #2 rstN = 1'b0;
    #1 check("R3 async", 0);
    @(negedge clk);
    check("R3 held", 0);
    rstN = 1'b1;
    applyCheck(56'hFFFFFFFFFFFFFF, 1785, "R2");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule